// File: doc/BRIEF.md
# Accumulator ALU with Input Scaler

This block is the arithmetic core of a fixed-point datapath. It holds a 32-bit accumulator. Every operation uses the accumulator as one input and writes its result back into the accumulator. The second input can come from one of two places. The first is a 32-bit product word that the multiplier side has already scaled. The second is a 16-bit data word, which may be a memory word or an immediate. A data word passes through a left-shifting input scaler, which sign-extends it unless a suppress bit is set.

The block offers load, add, subtract and the three bitwise operations. It also has load, add and subtract variants that take their shift count from the four low bits of a temporary register; these are useful for denormalising floating values and for gain control. Two further operations complete the set. A normalize step shifts the accumulator left by one place while it still holds a redundant sign bit. A bit test copies one selected bit of a data word into a test flag. Every operation finishes in one clock cycle.

Top module: `calu_core`

## Requirements
- R1: On synchronous reset the accumulator, carry flag, overflow flag and test flag are all 0.
- R2: LOAD (op_code 0) writes the second operand into the accumulator. The second operand is prod_in when use_prod is 1, and the scaled data word when use_prod is 0.
- R3: The input scaler shifts data_in left by shift_amt places. Before the shift it extends the word to 32 bits: with its sign bit when sx_off is 0, and with zeros when sx_off is 1.
- R4: AND (3), OR (4) and XOR (5) combine the accumulator bitwise with the second operand. The carry and overflow flags keep their values.
- R5: ADD (1) writes acc + operand. The carry flag takes the carry out of bit 31. The overflow flag is set when the signed 32-bit result overflows and cleared when it does not.
- R6: SUB (2) writes acc - operand. The carry flag is 1 when the unsigned subtraction borrows. The overflow flag is set when the signed 32-bit result overflows and cleared when it does not.
- R7: LOADT (6), ADDT (7) and SUBT (8) behave like LOAD, ADD and SUB with two differences: the scaler shift count is treg_low rather than shift_amt, and the operand is always the data word, whatever the value of use_prod.
- R8: NORM (9) shifts the accumulator left by one place when it is nonzero and bits 31 and 30 are equal. In every other case the accumulator is unchanged. NORM never changes the flags.
- R9: BITT (10) copies data_in[15 - treg_low] into the test flag. The accumulator, carry flag and overflow flag are unchanged.
- R10: When op_valid is 0, or when op_code is 11 to 15, the accumulator and all flags keep their values.
- R11: The result of an operation presented at a rising clock edge is visible on the outputs immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Executes op_code on this edge |
| op_code | input | 4 | Operation select |
| data_in | input | 16 | Data word operand |
| prod_in | input | 32 | Scaled product operand |
| use_prod | input | 1 | Selects prod_in as the operand for the plain operations |
| shift_amt | input | 4 | Scaler shift count for the plain operations |
| sx_off | input | 1 | Suppresses sign extension in the scaler |
| treg_low | input | 4 | Low bits of the temporary register |
| acc | output | 32 | Accumulator |
| carry | output | 1 | Carry/borrow flag |
| ovf | output | 1 | Signed overflow flag |
| tflag | output | 1 | Bit-test flag |

## Verification
The bench builds the block with its default parameters: a 16-bit data word, a 32-bit accumulator and a 4-bit shift count. With these values the largest shift, 15, moves the data sign bit into accumulator bit 30. The bit-test index also reaches both ends of the data word. Both overflow edges, 0x7FFFFFFF + 1 and 0x80000000 - 1, can be reached from loads of the product operand. These loads also reach all three normalize cases: the zero case, the case where bits 31 and 30 differ, and the case where the step shifts.

// File: rtl/calu_pkg.sv
package calu_pkg;
  typedef enum logic [3:0] {
    OP_LOAD  = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_LOADT = 4'd6,
    OP_ADDT  = 4'd7,
    OP_SUBT  = 4'd8,
    OP_NORM  = 4'd9,
    OP_BITT  = 4'd10
  } calu_op_e;
endpackage

// File: rtl/calu_scaler.sv
module calu_scaler #(
  parameter int DATA_W  = 16,
  parameter int ACC_W   = 32,
  parameter int SHIFT_W = 4
) (
  input  logic [DATA_W-1:0]  word_i,
  input  logic [SHIFT_W-1:0] amt_i,
  input  logic               zero_ext_i,
  output logic [ACC_W-1:0]   scaled_o
);
  localparam int EXT_W = ACC_W - DATA_W;

  logic [ACC_W-1:0] widened;

  always_comb begin
    if (zero_ext_i) widened = {{EXT_W{1'b0}}, word_i};
    else            widened = {{EXT_W{word_i[DATA_W-1]}}, word_i};
    scaled_o = widened << amt_i;
  end
endmodule

// File: rtl/calu_arith.sv
module calu_arith
  import calu_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  calu_op_e         op_i,
  input  logic [ACC_W-1:0] a_i,
  input  logic [ACC_W-1:0] b_i,
  output logic [ACC_W-1:0] res_o,
  output logic             res_we_o,
  output logic             flag_we_o,
  output logic             carry_o,
  output logic             ovf_o
);
  logic [ACC_W:0] sum_w;
  logic [ACC_W:0] diff_w;

  always_comb begin
    sum_w     = {1'b0, a_i} + {1'b0, b_i};
    diff_w    = {1'b0, a_i} - {1'b0, b_i};
    res_o     = a_i;
    res_we_o  = 1'b0;
    flag_we_o = 1'b0;
    carry_o   = 1'b0;
    ovf_o     = 1'b0;
    unique case (op_i)
      OP_LOAD, OP_LOADT: begin
        res_o    = b_i;
        res_we_o = 1'b1;
      end
      OP_ADD, OP_ADDT: begin
        res_o     = sum_w[ACC_W-1:0];
        res_we_o  = 1'b1;
        flag_we_o = 1'b1;
        carry_o   = sum_w[ACC_W];
        ovf_o     = (a_i[ACC_W-1] == b_i[ACC_W-1]) &&
                    (sum_w[ACC_W-1] != a_i[ACC_W-1]);
      end
      OP_SUB, OP_SUBT: begin
        res_o     = diff_w[ACC_W-1:0];
        res_we_o  = 1'b1;
        flag_we_o = 1'b1;
        carry_o   = diff_w[ACC_W];
        ovf_o     = (a_i[ACC_W-1] != b_i[ACC_W-1]) &&
                    (diff_w[ACC_W-1] != a_i[ACC_W-1]);
      end
      OP_AND: begin
        res_o    = a_i & b_i;
        res_we_o = 1'b1;
      end
      OP_OR: begin
        res_o    = a_i | b_i;
        res_we_o = 1'b1;
      end
      OP_XOR: begin
        res_o    = a_i ^ b_i;
        res_we_o = 1'b1;
      end
      default: begin
        res_we_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/calu_norm.sv
module calu_norm #(
  parameter int ACC_W = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             shifted_o
);
  always_comb begin
    shifted_o = (acc_i != '0) && (acc_i[ACC_W-1] == acc_i[ACC_W-2]);
    acc_o     = shifted_o ? {acc_i[ACC_W-2:0], 1'b0} : acc_i;
  end
endmodule

// File: rtl/calu_core.sv
module calu_core
  import calu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ACC_W   = 32,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic [3:0]         op_code,
  input  logic [DATA_W-1:0]  data_in,
  input  logic [ACC_W-1:0]   prod_in,
  input  logic               use_prod,
  input  logic [SHIFT_W-1:0] shift_amt,
  input  logic               sx_off,
  input  logic [SHIFT_W-1:0] treg_low,
  output logic [ACC_W-1:0]   acc,
  output logic               carry,
  output logic               ovf,
  output logic               tflag
);
  localparam logic [SHIFT_W-1:0] TOP_BIT = SHIFT_W'(DATA_W - 1);

  calu_op_e           op;
  logic               t_variant;
  logic [SHIFT_W-1:0] scale_amt;
  logic [ACC_W-1:0]   scaled;
  logic [ACC_W-1:0]   operand;
  logic [ACC_W-1:0]   arith_res;
  logic               arith_we, flag_we, arith_c, arith_v;
  logic [ACC_W-1:0]   norm_res;
  logic               norm_shift;
  logic [SHIFT_W-1:0] bit_idx;

  always_comb begin
    op        = calu_op_e'(op_code);
    t_variant = (op == OP_LOADT) || (op == OP_ADDT) || (op == OP_SUBT);
    scale_amt = t_variant ? treg_low : shift_amt;
    operand   = (use_prod && !t_variant) ? prod_in : scaled;
    bit_idx   = TOP_BIT - treg_low;
  end

  calu_scaler #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_scaler (
    .word_i     (data_in),
    .amt_i      (scale_amt),
    .zero_ext_i (sx_off),
    .scaled_o   (scaled)
  );

  calu_arith #(.ACC_W(ACC_W)) u_arith (
    .op_i      (op),
    .a_i       (acc),
    .b_i       (operand),
    .res_o     (arith_res),
    .res_we_o  (arith_we),
    .flag_we_o (flag_we),
    .carry_o   (arith_c),
    .ovf_o     (arith_v)
  );

  calu_norm #(.ACC_W(ACC_W)) u_norm (
    .acc_i     (acc),
    .acc_o     (norm_res),
    .shifted_o (norm_shift)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      carry <= 1'b0;
      ovf   <= 1'b0;
      tflag <= 1'b0;
    end else if (op_valid) begin
      if (arith_we) acc <= arith_res;
      if (op == OP_NORM && norm_shift) acc <= norm_res;
      if (flag_we) begin
        carry <= arith_c;
        ovf   <= arith_v;
      end
      if (op == OP_BITT) tflag <= data_in[bit_idx];
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_code > 4'd10) |=> ($stable(acc) && $stable(carry) && $stable(ovf) && $stable(tflag))); // R10
  AST_BITT_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd10) |=> ($stable(acc) && $stable(carry) && $stable(ovf))); // R9
  AST_NORM_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd9 && acc == '0) |=> (acc == '0)); // R8
  AST_NORM_SIGN_STOPS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd9 && acc[ACC_W-1] != acc[ACC_W-2]) |=> $stable(acc)); // R8
  AST_NORM_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd9) |=> ($stable(carry) && $stable(ovf))); // R8
  AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 4'd3 || op_code == 4'd4 || op_code == 4'd5)) |=> ($stable(carry) && $stable(ovf))); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (acc == '0 && !carry && !ovf && !tflag)); // R1
endmodule

// File: tb/test_calu_core.sv
module test_calu_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [15:0] data_in;
  logic [31:0] prod_in;
  logic        use_prod;
  logic [3:0]  shift_amt;
  logic        sx_off;
  logic [3:0]  treg_low;
  logic [31:0] acc;
  logic        carry, ovf, tflag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  calu_core i_calu_core (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .data_in(data_in), .prod_in(prod_in), .use_prod(use_prod),
    .shift_amt(shift_amt), .sx_off(sx_off), .treg_low(treg_low),
    .acc(acc), .carry(carry), .ovf(ovf), .tflag(tflag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one operation at a falling edge; outputs are sampled one falling edge later (R11)
  task automatic run_op(input logic [3:0] code, input logic [15:0] d, input logic [31:0] p,
                        input logic up, input logic [3:0] sh, input logic sxo,
                        input logic [3:0] tr, input logic vld);
    op_code = code; data_in = d; prod_in = p; use_prod = up;
    shift_amt = sh; sx_off = sxo; treg_low = tr; op_valid = vld;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic set_acc(input logic [31:0] v);
    run_op(4'd0, 16'h0, v, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1);
  endtask

  task automatic t_reset;
    chk("R1 acc", acc, 32'h0);
    chk("R1 carry", {31'b0, carry}, 32'h0);
    chk("R1 ovf", {31'b0, ovf}, 32'h0);
    chk("R1 tflag", {31'b0, tflag}, 32'h0);
  endtask

  task automatic t_load;
    run_op(4'd0, 16'h8001, 32'h0, 1'b0, 4'd4, 1'b0, 4'd0, 1'b1);
    chk("R3 sign-extended load (R11 one cycle)", acc, 32'hFFF80010);
    run_op(4'd0, 16'h8001, 32'h0, 1'b0, 4'd4, 1'b1, 4'd0, 1'b1);
    chk("R3 zero-extended load", acc, 32'h00080010);
    run_op(4'd0, 16'h7FFF, 32'h0, 1'b0, 4'd15, 1'b0, 4'd0, 1'b1);
    chk("R3 max shift", acc, 32'h3FFF8000);
    run_op(4'd0, 16'hFFFF, 32'h12345678, 1'b1, 4'd3, 1'b0, 4'd0, 1'b1);
    chk("R2 product load", acc, 32'h12345678);
  endtask

  task automatic t_add_sub;
    set_acc(32'h7FFFFFFF);
    run_op(4'd1, 16'h0, 32'h1, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1);
    chk("R5 add overflow acc", acc, 32'h80000000);
    chk("R5 add overflow flags", {30'b0, carry, ovf}, 32'h1);
    set_acc(32'hFFFFFFFF);
    run_op(4'd1, 16'h0001, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1);
    chk("R5 add carry acc", acc, 32'h0);
    chk("R5 add carry flags", {30'b0, carry, ovf}, 32'h2);
    set_acc(32'h0);
    run_op(4'd2, 16'h0001, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1);
    chk("R6 sub borrow acc", acc, 32'hFFFFFFFF);
    chk("R6 sub borrow flags", {30'b0, carry, ovf}, 32'h2);
    set_acc(32'h80000000);
    run_op(4'd2, 16'h0, 32'h1, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1);
    chk("R6 sub overflow acc", acc, 32'h7FFFFFFF);
    chk("R6 sub overflow flags", {30'b0, carry, ovf}, 32'h1);
  endtask

  task automatic t_logic;
    // flags currently carry=0 ovf=1 from the previous SUB
    set_acc(32'hF0F0F0F0);
    run_op(4'd3, 16'h0, 32'hFF00FF00, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1);
    chk("R4 and", acc, 32'hF000F000);
    run_op(4'd4, 16'h00FF, 32'h0, 1'b0, 4'd0, 1'b1, 4'd0, 1'b1);
    chk("R4 or", acc, 32'hF000F0FF);
    run_op(4'd5, 16'h0, 32'hFFFFFFFF, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1);
    chk("R4 xor", acc, 32'h0FFF0F00);
    chk("R4 flags held", {30'b0, carry, ovf}, 32'h1);
  endtask

  task automatic t_treg;
    run_op(4'd6, 16'h0001, 32'hDEADBEEF, 1'b1, 4'd0, 1'b0, 4'd15, 1'b1);
    chk("R7 loadt ignores use_prod and shift_amt", acc, 32'h00008000);
    run_op(4'd7, 16'hFFFF, 32'h0, 1'b1, 4'd9, 1'b0, 4'd4, 1'b1);
    chk("R7 addt", acc, 32'h00007FF0);
    chk("R7 addt flags", {30'b0, carry, ovf}, 32'h2);
    run_op(4'd8, 16'h0800, 32'h0, 1'b1, 4'd0, 1'b1, 4'd4, 1'b1);
    chk("R7 subt", acc, 32'hFFFFFFF0);
    chk("R7 subt flags", {30'b0, carry, ovf}, 32'h2);
  endtask

  task automatic t_norm;
    set_acc(32'h00000001);
    run_op(4'd9, 16'h0, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1);
    chk("R8 norm shifts", acc, 32'h00000002);
    set_acc(32'h40000000);
    run_op(4'd9, 16'h0, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1);
    chk("R8 norm stops on differing top bits", acc, 32'h40000000);
    set_acc(32'hC0000000);
    run_op(4'd9, 16'h0, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1);
    chk("R8 norm negative", acc, 32'h80000000);
    set_acc(32'h0);
    run_op(4'd9, 16'h0, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1);
    chk("R8 norm zero", acc, 32'h0);
    chk("R8 flags held", {30'b0, carry, ovf}, 32'h2);
  endtask

  task automatic t_bitt;
    set_acc(32'h13579BDF);
    run_op(4'd10, 16'h8000, 32'h0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1);
    chk("R9 bit 15", {31'b0, tflag}, 32'h1);
    run_op(4'd10, 16'h8000, 32'h0, 1'b0, 4'd0, 1'b0, 4'd1, 1'b1);
    chk("R9 bit 14", {31'b0, tflag}, 32'h0);
    run_op(4'd10, 16'h0001, 32'h0, 1'b0, 4'd0, 1'b0, 4'd15, 1'b1);
    chk("R9 bit 0", {31'b0, tflag}, 32'h1);
    chk("R9 acc held", acc, 32'h13579BDF);
  endtask

  task automatic t_idle;
    run_op(4'd1, 16'h0, 32'h11111111, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0);
    chk("R10 invalid add ignored", acc, 32'h13579BDF);
    run_op(4'd12, 16'h0, 32'h11111111, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1);
    chk("R10 unused code acc", acc, 32'h13579BDF);
    chk("R10 unused code flags", {29'b0, carry, ovf, tflag}, 32'h5);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_code = 4'd0; data_in = '0; prod_in = '0;
    use_prod = 1'b0; shift_amt = '0; sx_off = 1'b0; treg_low = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_add_sub();
    t_logic();
    t_treg();
    t_norm();
    t_bitt();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule